// File: doc/BRIEF.md
# Serial In-System Programming Slave

This block lets an external programmer reach two on-chip byte arrays, a program (code) array and a data array, over a three-wire serial link: a serial clock, a host-to-device data line and a device-to-host data line. The link works only while an active-low programming-hold pin is held low. The serial clock is oversampled by the system clock. Serial-clock phases that are too short for the system clock rate are filtered out. Every transfer is a 32-bit instruction frame.

After the hold pin goes low, the host first sends an enable frame. The device echoes a byte of that frame so the host can confirm that it is in step. Only after this can the host erase, write, read or poll. Erase and write operations are self-timed by a countdown. While the countdown runs, the block reports busy and drops every frame except the poll.

Top module: `isp_serial_slave`

## Requirements
- R1: While `prog_hold_n` (after a two-flop synchronizer) is high, the link is idle: `sdo` is 0, serial-clock edges are ignored, a partly received frame is discarded and the enable state is cleared.
- R2: After the hold pin falls, a frame is acted on only after an enable frame (first byte 0xAC, second byte 0x53) has completed. Before that, writes and erases change nothing, `busy` stays low, and every fourth-byte response is 0x00.
- R3: A frame is 32 bits, most significant bit first, taken from `sdi` at each accepted rising serial-clock edge. Byte 1 is the opcode, bytes 2 and 3 form a 16-bit address (byte 2 high), and byte 4 is the write data.
- R4: `sdo` changes only at accepted falling serial-clock edges. During bytes 1 and 2 it returns 0. During byte 3 it echoes byte 2 of the same frame. During byte 4 it returns the response byte.
- R5: A serial-clock high or low phase lasting no more than MIN_PH system clocks is not recognised. MIN_PH is 2 when FAST_CLK=0 and 3 when FAST_CLK=1.
- R6: Chip erase (0xAC, 0x80, any, any) sets every location of both arrays to 0xFF and holds `busy` for ERASE_CYCLES clocks.
- R7: Code write (opcode 0x40) can only clear bits: the location becomes old AND data. It holds `busy` for PROG_CYCLES clocks. Code read (opcode 0x20) returns the location in byte 4.
- R8: Data write (opcode 0xC0) erases the location and then programs it, so the location becomes exactly the data byte. It holds `busy` for ERASE_CYCLES+PROG_CYCLES clocks. Data read (opcode 0xA0) returns the location in byte 4.
- R9: Poll (opcode 0xF0) returns 0x01 in byte 4 while a self-timed operation runs and 0x00 otherwise. The `busy` port is high for the same span.
- R10: A frame other than poll that completes while `busy` is high is dropped without effect.
- R11: The code array is addressed by the 16-bit address modulo CODE_DEPTH, and the data array by the address modulo DATA_DEPTH.
- R12: After system reset (`rst_n` low at a clock edge), both arrays hold 0xFF, `sdo` and `busy` are 0, and the enable state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| prog_hold_n | input | 1 | Active-low programming hold; the link is active while it is low |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| busy | output | 1 | High while a self-timed erase or program operation runs |

## Verification
A wrong bit count or a stray accepted serial-clock edge shows up within the same frame: the byte-3 echo and the byte-4 response arrive shifted, and the next read returns the wrong value. A wrong enable or busy state shows up on the next frame, either as a read that returns 0x00 instead of the stored byte or as a write that lands or is lost. The error becomes visible through a later read or poll. Errors in the array update rules (the AND on code writes, the replace on data writes, the erase of both arrays, address wrap-around) stay hidden until that location is read back, so every write is followed by a read of the same or an aliased address.

// File: rtl/isp_pkg.sv
// Shared constants and frame layout for the serial programming slave.
// Assumes frames are 32 bits, opcode first.
package isp_pkg;
    localparam logic [7:0] OP_SPECIAL = 8'hAC;  // enable / chip erase family
    localparam logic [7:0] KEY_ENABLE = 8'h53;  // second byte of enable frame
    localparam logic [7:0] KEY_ERASE  = 8'h80;  // second byte of chip erase
    localparam logic [7:0] OP_CODE_WR = 8'h40;
    localparam logic [7:0] OP_CODE_RD = 8'h20;
    localparam logic [7:0] OP_DATA_WR = 8'hC0;
    localparam logic [7:0] OP_DATA_RD = 8'hA0;
    localparam logic [7:0] OP_POLL    = 8'hF0;

    typedef struct packed {
        logic [7:0] op;
        logic [7:0] a_hi;
        logic [7:0] a_lo;
        logic [7:0] wdata;
    } isp_frame_t;
endpackage

// File: rtl/isp_link_filter.sv
// Synchronizes the hold, serial clock and serial data pins into the system
// clock domain, and filters the serial clock so that only phases longer than
// MIN_PH system clocks yield edges.
// Assumes all three pins are asynchronous to clk.
module isp_link_filter #(
    parameter int MIN_PH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_pin_n,
    input  logic sclk_pin,
    input  logic sdi_pin,
    output logic link_on,
    output logic sck_rise,
    output logic sck_fall,
    output logic sdi_s
);
    localparam int RW = $clog2(MIN_PH + 1);

    logic [2:0]    sync1, sync2;
    logic          lvl;
    logic [RW-1:0] run;

    // two-flop synchronizer for {hold, sclk, sdi}
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 3'b100;
            sync2 <= 3'b100;
        end else begin
            sync1 <= {hold_pin_n, sclk_pin, sdi_pin};
            sync2 <= sync1;
        end
    end

    assign link_on = !sync2[2];
    assign sdi_s   = sync2[0];

    // serial clock deglitch: the level flips after MIN_PH+1 differing samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl      <= 1'b0;
            run      <= '0;
            sck_rise <= 1'b0;
            sck_fall <= 1'b0;
        end else begin
            sck_rise <= 1'b0;
            sck_fall <= 1'b0;
            if (sync2[1] != lvl) begin
                if (run == RW'(MIN_PH)) begin
                    lvl      <= sync2[1];
                    run      <= '0;
                    sck_rise <= sync2[1] && link_on;
                    sck_fall <= !sync2[1] && link_on;
                end else begin
                    run <= run + 1'b1;
                end
            end else begin
                run <= '0;
            end
        end
    end
endmodule

// File: rtl/isp_frame_shifter.sv
// Assembles 32-bit frames from accepted rising edges and shifts the response
// out on accepted falling edges. Byte 3 echoes byte 2; byte 4 carries resp.
// Assumes rise and fall pulses last one clock and never coincide.
module isp_frame_shifter (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        link_on,
    input  logic        sck_rise,
    input  logic        sck_fall,
    input  logic        sdi,
    input  logic [7:0]  resp,
    output logic [31:0] frame,
    output logic        frame_done,
    output logic        sdo
);
    logic [4:0] bit_cnt;
    logic [6:0] rem;

    // receive: shift in on rise, flag completion after the 32nd bit
    always_ff @(posedge clk) begin
        if (!rst_n || !link_on) begin
            frame      <= '0;
            bit_cnt    <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (sck_rise) begin
                frame      <= {frame[30:0], sdi};
                bit_cnt    <= bit_cnt + 1'b1;
                frame_done <= (bit_cnt == 5'd31);
            end
        end
    end

    // transmit: load echo or response at byte starts, otherwise shift
    always_ff @(posedge clk) begin
        if (!rst_n || !link_on) begin
            sdo <= 1'b0;
            rem <= '0;
        end else if (sck_fall) begin
            if (bit_cnt == 5'd16) begin
                sdo <= frame[7];
                rem <= frame[6:0];
            end else if (bit_cnt == 5'd24) begin
                sdo <= resp[7];
                rem <= resp[6:0];
            end else begin
                sdo <= rem[6];
                rem <= {rem[5:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/isp_mem_engine.sv
// Holds the enable gate, the self-timed countdown and both byte arrays, and
// forms the byte-4 response from the partly received frame.
// Assumes the depths are powers of two no larger than 65536.
module isp_mem_engine
    import isp_pkg::*;
#(
    parameter int CODE_DEPTH   = 64,
    parameter int DATA_DEPTH   = 32,
    parameter int PROG_CYCLES  = 50,
    parameter int ERASE_CYCLES = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        link_on,
    input  logic        frame_done,
    input  logic [31:0] frame,
    output logic [7:0]  resp,
    output logic        prog_en,
    output logic        busy
);
    localparam int CAW = $clog2(CODE_DEPTH);
    localparam int DAW = $clog2(DATA_DEPTH);
    localparam int TW  = $clog2(ERASE_CYCLES + PROG_CYCLES + 1);

    isp_frame_t      f;
    logic [23:0]     hdr;
    logic [CAW-1:0]  c_idx, c_ridx;
    logic [DAW-1:0]  d_idx, d_ridx;
    logic            accept, is_erase, is_enable;
    logic [TW-1:0]   timer;
    logic [7:0]      code_mem [CODE_DEPTH];
    logic [7:0]      data_mem [DATA_DEPTH];

    assign f         = frame;
    assign hdr       = frame[23:0];
    assign c_idx     = CAW'({f.a_hi, f.a_lo} % 16'(CODE_DEPTH));
    assign d_idx     = DAW'({f.a_hi, f.a_lo} % 16'(DATA_DEPTH));
    assign c_ridx    = CAW'(hdr[15:0] % 16'(CODE_DEPTH));
    assign d_ridx    = DAW'(hdr[15:0] % 16'(DATA_DEPTH));
    assign is_enable = (f.op == OP_SPECIAL) && (f.a_hi == KEY_ENABLE);
    assign is_erase  = (f.op == OP_SPECIAL) && (f.a_hi == KEY_ERASE);
    assign accept    = frame_done && prog_en && !busy;
    assign busy      = (timer != '0);

    // enable gate: set by an enable frame, cleared when the link goes idle
    always_ff @(posedge clk) begin
        if (!rst_n || !link_on) prog_en <= 1'b0;
        else if (frame_done && is_enable) prog_en <= 1'b1;
    end

    // self-timed countdown loaded by accepted erase or write frames
    always_ff @(posedge clk) begin
        if (!rst_n)                              timer <= '0;
        else if (accept && is_erase)             timer <= TW'(ERASE_CYCLES);
        else if (accept && f.op == OP_CODE_WR)   timer <= TW'(PROG_CYCLES);
        else if (accept && f.op == OP_DATA_WR)   timer <= TW'(ERASE_CYCLES + PROG_CYCLES);
        else if (busy)                           timer <= timer - 1'b1;
    end

    // code array: erase to 0xFF, program clears bits only
    always_ff @(posedge clk) begin
        if (!rst_n || (accept && is_erase)) begin
            for (int i = 0; i < CODE_DEPTH; i++) code_mem[i] <= 8'hFF;
        end else if (accept && f.op == OP_CODE_WR) begin
            code_mem[c_idx] <= code_mem[c_idx] & f.wdata;
        end
    end

    // data array: erase to 0xFF, write erases then programs the byte
    always_ff @(posedge clk) begin
        if (!rst_n || (accept && is_erase)) begin
            for (int i = 0; i < DATA_DEPTH; i++) data_mem[i] <= 8'hFF;
        end else if (accept && f.op == OP_DATA_WR) begin
            data_mem[d_idx] <= f.wdata;
        end
    end

    // byte-4 response from the opcode and address already received
    always_comb begin
        resp = 8'h00;
        if (prog_en) begin
            if (hdr[23:16] == OP_POLL)                   resp = {7'b0, busy};
            else if (!busy && hdr[23:16] == OP_CODE_RD)  resp = code_mem[c_ridx];
            else if (!busy && hdr[23:16] == OP_DATA_RD)  resp = data_mem[d_ridx];
        end
    end
endmodule

// File: rtl/isp_serial_slave.sv
// Top of the serial programming slave: pin filter, frame shifter and memory
// engine. FAST_CLK picks the longer minimum serial clock phase for fast
// system clocks.
// Assumes rst_n is synchronous to clk.
module isp_serial_slave #(
    parameter int CODE_DEPTH   = 64,
    parameter int DATA_DEPTH   = 32,
    parameter bit FAST_CLK     = 1'b0,
    parameter int PROG_CYCLES  = 50,
    parameter int ERASE_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_hold_n,
    input  logic sclk,
    input  logic sdi,
    output logic sdo,
    output logic busy
);
    localparam int MIN_PH = FAST_CLK ? 3 : 2;

    logic        link_on, sck_rise, sck_fall, sdi_s;
    logic        frame_done, prog_en;
    logic [31:0] frame;
    logic [7:0]  resp;

    isp_link_filter #(.MIN_PH(MIN_PH)) i_filter (
        .clk(clk), .rst_n(rst_n), .hold_pin_n(prog_hold_n), .sclk_pin(sclk),
        .sdi_pin(sdi), .link_on(link_on), .sck_rise(sck_rise),
        .sck_fall(sck_fall), .sdi_s(sdi_s)
    );

    isp_frame_shifter i_shifter (
        .clk(clk), .rst_n(rst_n), .link_on(link_on), .sck_rise(sck_rise),
        .sck_fall(sck_fall), .sdi(sdi_s), .resp(resp), .frame(frame),
        .frame_done(frame_done), .sdo(sdo)
    );

    isp_mem_engine #(
        .CODE_DEPTH(CODE_DEPTH), .DATA_DEPTH(DATA_DEPTH),
        .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
    ) i_engine (
        .clk(clk), .rst_n(rst_n), .link_on(link_on), .frame_done(frame_done),
        .frame(frame), .resp(resp), .prog_en(prog_en), .busy(busy)
    );
endmodule

// File: rtl/isp_serial_slave_chk.sv
// Protocol checks for the serial programming slave, bound to the top module.
module isp_serial_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic link_on,
    input logic sck_fall,
    input logic frame_done,
    input logic prog_en,
    input logic sdo,
    input logic busy
);
    // R1: idle link drives zero
    assert_idle_sdo_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !link_on |=> (sdo == 1'b0));

    // R4: sdo only moves on an accepted falling edge
    assert_sdo_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (link_on && !sck_fall) |=> $stable(sdo));

    // R2: enable only rises at a completed frame
    assert_enable_at_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_en) |-> $past(frame_done));

    // R2: a frame before enable starts no operation
    assert_no_op_unenabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !prog_en && !busy) |=> !busy);

    // R10: busy starts only from an enabled frame
    assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(frame_done && prog_en));
endmodule

bind isp_serial_slave isp_serial_slave_chk i_chk (
    .clk(clk), .rst_n(rst_n), .link_on(link_on), .sck_fall(sck_fall),
    .frame_done(frame_done), .prog_en(prog_en), .sdo(sdo), .busy(busy)
);

// File: tb/test_isp_serial_slave.sv
module test_isp_serial_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 12;
    localparam int WDOG       = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_hold_n = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdo, busy;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic [7:0] code_m [64];
    logic [7:0] data_m [32];
    logic [7:0] b3, b4;

    always #(CLK_PERIOD/2) clk = ~clk;

    isp_serial_slave i_isp_serial_slave (
        .clk(clk), .rst_n(rst_n), .prog_hold_n(prog_hold_n), .sclk(sclk),
        .sdi(sdi), .sdo(sdo), .busy(busy)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WDOG && !done) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run did not end, actual %0d cycles expected < %0d", cyc, WDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [7:0] exp_code_wr(input logic [7:0] old, input logic [7:0] d);
        return old & d;
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] w, input int n, input bit glitch,
                             output logic [31:0] r);
        r = '0;
        for (int i = 31; i > 31 - n; i--) begin
            sdi = w[i];
            if (glitch) begin
                clks(3); sclk = 1'b1; clks(2); sclk = 1'b0; clks(HALF - 5);
            end else begin
                clks(HALF);
            end
            r[i] = sdo;
            sclk = 1'b1;
            clks(HALF);
            sclk = 1'b0;
        end
        clks(HALF);
    endtask

    task automatic xfer(input logic [31:0] w, input bit glitch);
        logic [31:0] r;
        send_bits(w, 32, glitch, r);
        b3 = r[15:8];
        b4 = r[7:0];
    endtask

    task automatic wait_idle;
        while (busy) @(negedge clk);
        clks(2);
    endtask

    task automatic code_wr(input logic [15:0] a, input logic [7:0] d);
        xfer({8'h40, a, d}, 1'b0);
        code_m[a % 64] = exp_code_wr(code_m[a % 64], d);
        wait_idle();
    endtask

    task automatic data_wr(input logic [15:0] a, input logic [7:0] d);
        xfer({8'hC0, a, d}, 1'b0);
        data_m[a % 32] = d;
        wait_idle();
    endtask

    initial begin
        logic [31:0] junk;
        for (int i = 0; i < 64; i++) code_m[i] = 8'hFF;
        for (int i = 0; i < 32; i++) data_m[i] = 8'hFF;
        void'($urandom(32'd1234));

        // R12: reset state
        clks(5);
        rst_n = 1'b1;
        clks(3);
        chk("R12 sdo after reset", {7'b0, sdo}, 8'h00);
        chk("R12 busy after reset", {7'b0, busy}, 8'h00);

        prog_hold_n = 1'b0;
        clks(4);

        // R2: frames before enable have no effect
        xfer(32'h20_0005_00, 1'b0);
        chk("R2 read before enable", b4, 8'h00);
        xfer(32'h40_0005_00, 1'b0);
        chk("R2 no busy before enable", {7'b0, busy}, 8'h00);

        // R4: enable frame, echo of byte 2 during byte 3
        xfer(32'hAC53_0000, 1'b0);
        chk("R4 echo of enable key", b3, 8'h53);
        chk("R4 byte4 of enable", b4, 8'h00);
        xfer(32'h20_0005_00, 1'b0);
        chk("R2 unenabled write left no mark", b4, 8'hFF);

        // R7: code write clears bits only, busy set
        xfer(32'h40_0005_3C, 1'b0);
        code_m[5] = exp_code_wr(code_m[5], 8'h3C);
        chk("R7 busy after code write", {7'b0, busy}, 8'h01);
        wait_idle();
        code_wr(16'h0005, 8'hF0);
        xfer(32'h20_0005_00, 1'b0);
        chk("R7 code AND rule", b4, code_m[5]);

        // R8: data write replaces; R9 poll during its countdown
        data_wr(16'h0003, 8'h3C);
        xfer(32'hC0_0003_F0, 1'b0);
        data_m[3] = 8'hF0;
        xfer(32'hF0_0000_00, 1'b0);
        chk("R9 poll while busy", b4, 8'h01);
        wait_idle();
        xfer(32'hF0_0000_00, 1'b0);
        chk("R9 poll idle", b4, 8'h00);
        xfer(32'hA0_0003_00, 1'b0);
        chk("R8 data replace", b4, 8'hF0);

        // R11: address wraps modulo depth
        data_wr(16'h0123, 8'h5A);
        xfer(32'hA0_0003_00, 1'b0);
        chk("R11 data alias", b4, 8'h5A);
        xfer(32'h20_FF05_00, 1'b0);
        chk("R11 code alias", b4, code_m[5]);

        // R6 and R10: chip erase, write during busy dropped
        xfer(32'hAC80_0000, 1'b0);
        for (int i = 0; i < 64; i++) code_m[i] = 8'hFF;
        for (int i = 0; i < 32; i++) data_m[i] = 8'hFF;
        xfer(32'h40_0005_00, 1'b0);
        chk("R10 still busy after dropped write", {7'b0, busy}, 8'h01);
        wait_idle();
        xfer(32'h20_0005_00, 1'b0);
        chk("R10 write during busy dropped", b4, 8'hFF);
        xfer(32'hA0_0003_00, 1'b0);
        chk("R6 data erased", b4, 8'hFF);

        // R5: short serial clock pulses ignored
        data_wr(16'h0007, 8'hA5);
        xfer(32'hA0_0007_00, 1'b1);
        chk("R5 glitch echo", b3, 8'h00);
        chk("R5 glitch read", b4, 8'hA5);

        // R1: hold release discards partial frame and enable
        send_bits(32'hC0_0007_00, 10, 1'b0, junk);
        prog_hold_n = 1'b1;
        clks(6);
        chk("R1 sdo idle", {7'b0, sdo}, 8'h00);
        prog_hold_n = 1'b0;
        clks(4);
        xfer(32'hA0_0007_00, 1'b0);
        chk("R1 enable cleared", b4, 8'h00);
        xfer(32'hAC53_0000, 1'b0);
        xfer(32'hA0_0007_00, 1'b0);
        chk("R1 partial frame discarded", b4, 8'hA5);

        // R3 R7 R8: random traffic against the model
        for (int k = 0; k < 24; k++) begin
            logic [15:0] a;
            logic [7:0]  d;
            int kind;
            a = 16'($urandom);
            d = 8'($urandom);
            kind = int'($urandom % 4);
            case (kind)
                0: code_wr(a, d);
                1: data_wr(a, d);
                2: begin
                    xfer({8'h20, a, 8'h00}, 1'b0);
                    chk("R3 R7 random code read", b4, code_m[a % 64]);
                end
                default: begin
                    xfer({8'hA0, a, 8'h00}, 1'b0);
                    chk("R3 R8 random data read", b4, data_m[a % 32]);
                end
            endcase
        end
        for (int i = 0; i < 4; i++) begin
            xfer({8'hA0, 16'(i), 8'h00}, 1'b0);
            chk("R8 final data sweep", b4, data_m[i]);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule